// File: doc/BRIEF.md
# Codec Serial Port Slave

This block is the digital serial port of a voice-band codec, seen from the codec side. One master clock drives everything. From it the block derives an internal sample clock, through a master divider, and a serial bit clock (SCLK), through a further serial divider. Every 256 ticks of the internal clock it raises a one-cycle sample request and captures a 16-bit word from a parallel sample source. It then sends that word MSB first on the serial output. A one-SCLK frame sync precedes the word, and a separate output-enable shows when the data pin is driven.

In the other direction, the block watches an input frame sync and shifts in 16-bit words on SCLK falling edges. Each completed word is presented on a parallel sink port with a one-cycle valid pulse. Words whose top bit is set are commands. A command either writes one of five 8-bit control registers or asks for a register's value to be returned in the next output frame. One register holds the two divider settings.

An asynchronous port-enable input stops SCLK, releases both serial outputs and makes the block ignore the serial inputs. The control registers keep their values while the port is disabled, and all timing restarts from zero when it is enabled again. An active-low reset clears everything.

Top module: `cdcSerialPort`

## Requirements
- R1: A word captured from `sampleIn` in the cycle `sampleReq` is high is sent on `sdo` MSB first. Each bit is launched at an SCLK rising edge and held for one full SCLK period, with `sdoOe` high for exactly those 16 periods.
- R2: `outFs` is high for exactly one SCLK period, the one just before the MSB. `sdoOe` is low during that period and again in the period after the LSB.
- R3: While the port is enabled, `sdo` and `outFs` change only in the cycle where `sclk` rises.
- R4: `inFs` is sampled on an SCLK falling edge. When it is seen high with no word in progress, the next 16 falling edges sample `sdi` MSB first. The word then appears on `rxWord` with a one-cycle `rxValid` pulse, and `inFs` is ignored while a word is in progress.
- R5: A received word with bit 15 = 1 and bit 14 = 0 writes bits 7:0 into the control register selected by bits 10:8 (0 to 4). Index values 5 to 7 change no register and read back as 0x00.
- R6: A received word with bit 15 = 1 and bit 14 = 1 makes the next output frame carry {2'b11, 3'b000, index[2:0], value[7:0]} instead of the sampled word.
- R7: Control register 1 sets the dividers. Bits 3:0 hold code c, which gives M = min(c+1, 5). Bits 7:4 hold code d, which gives S = 2^min(d,3). SCLK is high for M·S master cycles and low for M·S master cycles.
- R8: `sampleReq` is a one-cycle pulse that repeats every 256·M master cycles.
- R9: While `portEn` is low, `sdoOe` and `outFsOe` are low, `sclk` stays low, no `sampleReq` occurs, and activity on `sdi` and `inFs` produces no `rxValid`.
- R10: After `portEn` returns high, the control registers, including the divider settings, hold their earlier values. The timing restarts: the first `sampleReq` comes 256·M master cycles after the two-stage synchronised enable rises.
- R11: With `rstN` low, `sclk`, `sdoOe`, `outFsOe`, `rxValid` and `sampleReq` are low. Reset clears all control registers to 0x00, so the dividers return to M = S = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| portEn | input | 1 | Asynchronous serial port enable |
| sdi | input | 1 | Serial data in, sampled on SCLK falling edges |
| inFs | input | 1 | Input frame sync, one bit wide, before the MSB |
| sampleIn | input | 16 | Parallel sample source, captured on `sampleReq` |
| sclk | output | 1 | Serial bit clock |
| sdo | output | 1 | Serial data out value |
| sdoOe | output | 1 | Drive enable for `sdo` (low means high impedance) |
| outFs | output | 1 | Output frame sync value |
| outFsOe | output | 1 | Drive enable for `outFs` |
| sampleReq | output | 1 | One-cycle request for a new output sample |
| rxWord | output | 16 | Last word received on `sdi` |
| rxValid | output | 1 | One-cycle pulse when `rxWord` updates |

## Verification
The two serial directions work in the same SCLK periods. Each period launches an output bit at the rising edge and samples an input bit at the falling edge, and the input word can open in the very period that carries the output frame sync. The bench provokes this on purpose: it raises `inFs` at the rise where it first sees `outFs`, so the two words overlap bit for bit. Both words must come out intact, and the framing and enable timing of the output must be unchanged. The same overlap carries command words, so a register write or readback request lands while an output frame is in flight. The bench judges this by the unchanged current frame and by the readback in the following frame.

// File: rtl/cdcSpPkg.sv
package cdcSpPkg;
  typedef struct packed {
    logic sampleStb;  // capture a new sample word
    logic txLoad;     // load the transmit shifter (frame sync period)
    logic txShift;    // launch next output bit
    logic rxShift;    // sample one input bit
    logic rxLast;     // this sample completes an input word
  } spStb_t;
endpackage

// File: rtl/cdcSpCtrl.sv
module cdcSpCtrl
  import cdcSpPkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int SAMPLE_TICKS = 256,
  parameter int MDIV_MAX     = 5,
  parameter int SDIV_LOG_MAX = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enS,
  input  logic       inFs,
  input  logic [3:0] mCode,
  input  logic [3:0] sCode,
  output logic       sclk,
  output logic       outFs,
  output logic       sdoEn,
  output logic       sampleReq,
  output spStb_t     stb
);
  localparam int MCNT_W = $clog2(MDIV_MAX + 1);
  localparam int SMAX   = 1 << SDIV_LOG_MAX;
  localparam int SCNT_W = $clog2(SMAX + 1);
  localparam int TICK_W = $clog2(SAMPLE_TICKS);
  localparam int BIT_W  = $clog2(WORD_W + 2);

  logic [MCNT_W-1:0] mCnt, mLim;
  logic [SCNT_W-1:0] sCnt, sLim;
  logic [TICK_W-1:0] tCnt;
  logic [BIT_W-1:0]  txCnt, rxCnt;
  logic [1:0]        sExp;
  logic              dmTick, toggle, riseStb, fallStb, pend;

  always_comb begin
    if (mCode >= 4'(MDIV_MAX - 1)) mLim = MCNT_W'(MDIV_MAX);
    else                           mLim = MCNT_W'(mCode) + 1'b1;
    if (sCode >= 4'(SDIV_LOG_MAX)) sExp = 2'(SDIV_LOG_MAX);
    else                           sExp = sCode[1:0];
    sLim = SCNT_W'(1) << sExp;
  end

  assign dmTick    = enS && (mCnt >= mLim - 1'b1);
  assign toggle    = dmTick && (sCnt >= sLim - 1'b1);
  assign riseStb   = toggle && !sclk;
  assign fallStb   = toggle && sclk;
  assign sampleReq = dmTick && (tCnt == TICK_W'(SAMPLE_TICKS - 1));

  assign stb.sampleStb = sampleReq;
  assign stb.txLoad    = riseStb && (txCnt == '0) && pend;
  assign stb.txShift   = riseStb && (txCnt >= BIT_W'(2));
  assign stb.rxShift   = fallStb && (rxCnt != '0);
  assign stb.rxLast    = fallStb && (rxCnt == BIT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || !enS) begin
      mCnt  <= '0;
      sCnt  <= '0;
      tCnt  <= '0;
      txCnt <= '0;
      rxCnt <= '0;
      sclk  <= 1'b0;
      outFs <= 1'b0;
      sdoEn <= 1'b0;
      pend  <= 1'b0;
    end else begin
      mCnt <= dmTick ? '0 : mCnt + 1'b1;
      if (dmTick) begin
        sCnt <= toggle ? '0 : sCnt + 1'b1;
        tCnt <= sampleReq ? '0 : tCnt + 1'b1;
      end
      if (toggle) sclk <= !sclk;
      if (sampleReq)       pend <= 1'b1;
      else if (stb.txLoad) pend <= 1'b0;
      if (riseStb) begin
        if (txCnt == '0) begin
          if (pend) begin
            outFs <= 1'b1;
            txCnt <= BIT_W'(WORD_W + 1);
          end
        end else begin
          outFs <= 1'b0;
          txCnt <= txCnt - 1'b1;
          sdoEn <= (txCnt >= BIT_W'(2));
        end
      end
      if (fallStb) begin
        if (rxCnt == '0) begin
          if (inFs) rxCnt <= BIT_W'(WORD_W);
        end else begin
          rxCnt <= rxCnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cdcSpData.sv
module cdcSpData
  import cdcSpPkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 5,
  parameter int DIV_REG  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  spStb_t            stb,
  input  logic              sdi,
  input  logic [WORD_W-1:0] sampleIn,
  output logic              sdo,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic [REG_W-1:0]  divCfg
);
  localparam int IDX_W   = 3;
  localparam int CMD_BIT = WORD_W - 1;
  localparam int RD_BIT  = WORD_W - 2;
  localparam int PAD_W   = WORD_W - 2 - IDX_W - REG_W;

  logic [NUM_REGS*REG_W-1:0] regFlat;
  logic [WORD_W-1:0]         pendWord, txSh, rxSh, rxNext, rdWord;
  logic [IDX_W-1:0]          rxIdx;
  logic [REG_W-1:0]          rdVal;
  logic                      isCmd, isRd, rdPend;

  assign rxNext = {rxSh[WORD_W-2:0], sdi};
  assign rxIdx  = rxNext[REG_W +: IDX_W];
  assign isCmd  = rxNext[CMD_BIT];
  assign isRd   = rxNext[RD_BIT];
  assign divCfg = regFlat[DIV_REG*REG_W +: REG_W];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (stb.rxLast && isCmd && !isRd && rxIdx == IDX_W'(g))
        q <= rxNext[REG_W-1:0];
    end
    assign regFlat[g*REG_W +: REG_W] = q;
  end

  always_comb begin
    rdVal = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rxIdx == IDX_W'(i)) rdVal = regFlat[i*REG_W +: REG_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWord <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      rxWord   <= '0;
      rdWord   <= '0;
      rdPend   <= 1'b0;
      rxValid  <= 1'b0;
      sdo      <= 1'b0;
    end else begin
      rxValid <= stb.rxLast;
      if (stb.sampleStb) pendWord <= sampleIn;
      if (stb.txLoad) begin
        txSh   <= rdPend ? rdWord : pendWord;
        rdPend <= 1'b0;
      end else if (stb.txShift) begin
        sdo  <= txSh[WORD_W-1];
        txSh <= {txSh[WORD_W-2:0], 1'b0};
      end
      if (stb.rxShift) rxSh <= rxNext;
      if (stb.rxLast) begin
        rxWord <= rxNext;
        if (isCmd && isRd) begin
          rdPend <= 1'b1;
          rdWord <= {2'b11, {PAD_W{1'b0}}, rxIdx, rdVal};
        end
      end
    end
  end
endmodule

// File: rtl/cdcSerialPort.sv
module cdcSerialPort
  import cdcSpPkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int REG_W        = 8,
  parameter int NUM_REGS     = 5,
  parameter int SAMPLE_TICKS = 256,
  parameter int MDIV_MAX     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              sdi,
  input  logic              inFs,
  input  logic [WORD_W-1:0] sampleIn,
  output logic              sclk,
  output logic              sdo,
  output logic              sdoOe,
  output logic              outFs,
  output logic              outFsOe,
  output logic              sampleReq,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);
  logic             enMeta, enSync, sdoEn;
  logic [REG_W-1:0] divCfg;
  spStb_t           stb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMeta <= 1'b0;
      enSync <= 1'b0;
    end else begin
      enMeta <= portEn;
      enSync <= enMeta;
    end
  end

  assign sdoOe   = sdoEn & enSync & portEn;
  assign outFsOe = enSync & portEn;

  cdcSpCtrl #(
    .WORD_W(WORD_W), .SAMPLE_TICKS(SAMPLE_TICKS), .MDIV_MAX(MDIV_MAX), .SDIV_LOG_MAX(3)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enS(enSync), .inFs(inFs),
    .mCode(divCfg[3:0]), .sCode(divCfg[7:4]),
    .sclk(sclk), .outFs(outFs), .sdoEn(sdoEn), .sampleReq(sampleReq), .stb(stb)
  );

  cdcSpData #(
    .WORD_W(WORD_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS), .DIV_REG(1)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdi(sdi), .sampleIn(sampleIn),
    .sdo(sdo), .rxWord(rxWord), .rxValid(rxValid), .divCfg(divCfg)
  );
endmodule

// File: rtl/cdcSerialPortChk.sv
module cdcSerialPortChk #(
  parameter int SAMPLE_TICKS = 256
) (
  input logic clk,
  input logic rstN,
  input logic portEn,
  input logic enSync,
  input logic sclk,
  input logic sdo,
  input logic sdoOe,
  input logic outFs,
  input logic sampleReq,
  input logic rxValid
);
  localparam int GAP_W = $clog2(SAMPLE_TICKS + 1);
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    gap <= '0;
    else if (!enSync || sampleReq) gap <= '0;
    else if (gap < GAP_W'(SAMPLE_TICKS)) gap <= gap + 1'b1;
  end

  assert_fs_no_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    outFs |-> !sdoOe);

  assert_launch_on_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enSync && $past(enSync) && !$rose(sclk)) |-> ($stable(sdo) && $stable(outFs)));

  assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_strobe_spacing_R8: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |-> (gap >= GAP_W'(SAMPLE_TICKS - 1)));

  assert_sclk_stops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!portEn && !$past(portEn) && !$past(portEn, 2)) |=> !sclk);
endmodule

bind cdcSerialPort cdcSerialPortChk #(.SAMPLE_TICKS(SAMPLE_TICKS)) uChk (.*);

// File: tb/cdcSerialPort_test.sv
`timescale 1ns/1ps
module cdcSerialPort_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portEn = 1'b1;
  logic        sdi = 1'b0;
  logic        inFs = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        sclk, sdo, sdoOe, outFs, outFsOe, sampleReq, rxValid;
  logic [15:0] rxWord;

  int checks = 0;
  int errors = 0;
  int rxCount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cdcSerialPort uut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .sdi(sdi), .inFs(inFs),
    .sampleIn(sampleIn), .sclk(sclk), .sdo(sdo), .sdoOe(sdoOe),
    .outFs(outFs), .outFsOe(outFsOe), .sampleReq(sampleReq),
    .rxWord(rxWord), .rxValid(rxValid)
  );

  always @(negedge clk) if (rxValid === 1'b1) rxCount++;

  // {sample word sent by the block, data word sent to the block}
  localparam logic [31:0] VEC [5] = '{
    {16'h8001, 16'h0001},
    {16'hFFFF, 16'h7FFF},
    {16'h0000, 16'h5A5A},
    {16'h1234, 16'h0F0F},
    {16'hC3A5, 16'h4000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitRise();
    logic prev;
    prev = sclk;
    @(negedge clk);
    while (!(sclk === 1'b1 && prev === 1'b0)) begin
      prev = sclk;
      @(negedge clk);
    end
  endtask

  // Output frame capture with an input word overlapped bit for bit.
  task automatic duplexFrame(input logic [15:0] sendW, output logic [15:0] got,
                             output logic fmtOk);
    fmtOk = 1'b1;
    got = '0;
    do waitRise(); while (outFs !== 1'b1);
    if (sdoOe !== 1'b0) fmtOk = 1'b0;
    inFs = 1'b1;
    sdi = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      waitRise();
      if (outFs !== 1'b0 || sdoOe !== 1'b1) fmtOk = 1'b0;
      got[i] = sdo;
      inFs = 1'b0;
      sdi = sendW[i];
    end
    waitRise();
    if (sdoOe !== 1'b0) fmtOk = 1'b0;
    sdi = 1'b0;
  endtask

  task automatic measureHigh(output int n);
    waitRise();
    n = 0;
    while (sclk === 1'b1) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measureGap(output int n);
    @(negedge clk);
    while (sampleReq !== 1'b1) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sampleReq !== 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic fmtOk;
    int n, rxBefore;
    bit ok;

    // R11: state during reset
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {27'd0, sclk, sdoOe, outFsOe, rxValid, sampleReq}, 32'd0);
    sampleIn = VEC[0][31:16];
    rstN = 1'b1;

    // R8: strobe period at M = 1
    measureGap(n);
    chk("R8 sample period M=1", n, 256);

    // Vector loop: R1, R2, R4 under several patterns
    for (int v = 0; v < 5; v++) begin
      rxBefore = rxCount;
      duplexFrame(VEC[v][15:0], got, fmtOk);
      if (v < 4) sampleIn = VEC[v+1][31:16];
      chk("R1 output word", got, VEC[v][31:16]);
      chk("R2 frame sync and enable", fmtOk, 1);
      repeat (2) @(negedge clk);
      chk("R4 received word", rxWord, VEC[v][15:0]);
      chk("R4 one valid pulse", rxCount - rxBefore, 1);
    end

    // R5 / R6: write index 2, read it back in the next frame
    sampleIn = 16'h2222;
    duplexFrame(16'h82A5, got, fmtOk);
    sampleIn = 16'h3333;
    duplexFrame(16'hC200, got, fmtOk);
    chk("R6 frame in flight untouched by read", got, 16'h3333);
    duplexFrame(16'h0000, got, fmtOk);
    chk("R6 readback replaces sample", got, 16'hC2A5);
    // R5: out-of-range index write ignored, reads back zero
    duplexFrame(16'h86FF, got, fmtOk);
    duplexFrame(16'hC600, got, fmtOk);
    duplexFrame(16'h0000, got, fmtOk);
    chk("R5 index 6 reads zero", got, 16'hC600);

    // R7: M code 2 -> 3, S code 1 -> 2
    duplexFrame(16'h8112, got, fmtOk);
    measureHigh(n);
    chk("R7 sclk high time", n, 6);
    measureGap(n);
    chk("R8 sample period M=3", n, 768);
    sampleIn = 16'hBEEF;
    duplexFrame(16'h0ACE, got, fmtOk);
    chk("R7 word at divided rate", got, 16'hBEEF);
    chk("R7 framing at divided rate", fmtOk, 1);
    repeat (2) @(negedge clk);
    chk("R7 received at divided rate", rxWord, 16'h0ACE);

    // R9: disabled port
    portEn = 1'b0;
    rxBefore = rxCount;
    repeat (4) @(negedge clk);
    ok = 1'b1;
    for (int c = 0; c < 200; c++) begin
      inFs = c[2];
      sdi = c[0];
      if (sclk !== 1'b0 || sampleReq !== 1'b0 || sdoOe !== 1'b0 || outFsOe !== 1'b0) ok = 1'b0;
      @(negedge clk);
    end
    inFs = 1'b0;
    sdi = 1'b0;
    chk("R9 outputs released and clock stopped", ok, 1);
    chk("R9 inputs ignored", rxCount - rxBefore, 0);

    // R10: re-enable keeps registers, restarts timing
    portEn = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sampleReq !== 1'b1 && n < 2000);
    chk("R10 first request after restart", (n >= 766 && n <= 772), 1);
    measureHigh(n);
    chk("R10 divider kept", n, 6);
    duplexFrame(16'hC200, got, fmtOk);
    duplexFrame(16'h0000, got, fmtOk);
    chk("R10 register kept", got, 16'hC2A5);

    // R11: reset clears registers and dividers
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 outputs in reset", {27'd0, sclk, sdoOe, outFsOe, rxValid, sampleReq}, 32'd0);
    rstN = 1'b1;
    measureHigh(n);
    chk("R11 divider cleared", n, 1);
    duplexFrame(16'hC200, got, fmtOk);
    duplexFrame(16'h0000, got, fmtOk);
    chk("R11 register cleared", got, 16'hC200);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule